// File: doc/BRIEF.md
# Serial-Wire Debug Line Reset and Connect Sequencer

This block brings a debug port from an unknown state (JTAG or serial-wire) into serial-wire mode and proves the connection. On a start pulse it clocks out a fixed switch pattern of 144 bits: a run of ones, a 16-bit switch word, and a second run of ones. It then sends a short run of driven-low idle bits and at once issues the identification read request. The block does not check what mode the port was in. Every start performs the full pattern.

The block releases the data line for the turnaround and takes the 3-bit acknowledge. On an OK acknowledge it also takes the 32-bit identification value and its parity bit. It then finishes with a turnaround and trailing idle bits. On any other acknowledge it adds a turnaround and stops. Retries are left to the transaction engine that uses the block. The reported status is that of the identification read. When the block is idle, the clock line rests high and the data line is released.

Top module: `swd_line_reset`

## Requirements
- R1: After reset, and whenever `busy` is low, `swclk` is 1 and `swdio_oe` is 0. After reset, `busy` and `done` are 0, `status` is 3 (no response) and `id_value` is 0.
- R2: A `start` pulse taken while idle sets `busy` in the next cycle. A `start` that arrives while `busy` is high is ignored and leaves the bit stream unchanged.
- R3: Each bit lasts 2*H clock cycles: H cycles with `swclk` low, then H cycles with it high. H is `half_period`, captured at start, and a value of 0 counts as 1.
- R4: `swdio_out` and `swdio_oe` change only at the cycle where `swclk` falls. They stay constant while `swclk` is high during a run.
- R5: The first 64 bits are driven as 1.
- R6: The next 16 bits are the switch word 0xE79E, sent least significant bit first.
- R7: Next come 64 more bits driven as 1, followed by 8 bits driven as 0.
- R8: Next comes the request byte 0xA5, sent least significant bit first, then one turnaround bit with `swdio_oe` = 0.
- R9: The block releases the line for 3 acknowledge bits. It samples `swdio_in` in the last cycle before each rising edge, and the first bit received is bit 0. The codes are OK = 3'b001, WAIT = 3'b010 and FAULT = 3'b100. On any code other than OK, one more undriven bit follows and the run ends with `status` set to 1 for WAIT, 2 for FAULT, or 3 for any other code.
- R10: On OK, the block receives 32 data bits (first bit is bit 0) and a parity bit. It then sends one undriven turnaround bit and 8 bits driven as 0. `status` is 0 when the XOR of the data bits and the parity bit is 0, and 4 (parity error) otherwise.
- R11: `done` is a one-cycle pulse in the cycle where `busy` falls. At that point `swclk` is 1 and `swdio_oe` is 0. `id_value` holds the received word only when `status` is 0 and is 0 otherwise. Both `status` and `id_value` hold until the next run ends.
- R12: Every accepted start repeats the whole sequence from the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a reset-and-connect run |
| half_period | input | HP_W | Clock cycles per half bit (0 counts as 1) |
| swdio_in | input | 1 | Data line as seen from the target |
| swclk | output | 1 | Serial-wire clock |
| swdio_out | output | 1 | Data value driven toward the target |
| swdio_oe | output | 1 | Data line drive enable |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| id_value | output | 32 | Identification word, valid when status is 0 |
| status | output | 3 | 0 OK, 1 WAIT, 2 FAULT, 3 no response, 4 parity error |

## Verification
The assertions check the line-level rules on every cycle. They cover the resting state of the clock and data lines while idle, data holding still while the clock is high, the length of every clock level against the captured half period, and the single-cycle completion pulse that coincides with `busy` falling. Only the bench scenarios can show the content of the stream: the switch word, the idle and request bits, and the points where the line is released. They also show how each acknowledge code, good or bad parity, and a zero half period map to the final status and identification value, and that a start arriving mid-run changes nothing.

// File: rtl/swd_lr_pkg.sv
// Shared types and constants for the line reset sequencer.
// Assumes acknowledge bits are collected with the first received bit in bit 0.
package swd_lr_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ONES_A,
        PH_MAGIC,
        PH_ONES_B,
        PH_GAP,
        PH_REQ,
        PH_TURN_A,
        PH_ACK,
        PH_DATA,
        PH_PAR,
        PH_TURN_B,
        PH_TAIL
    } lr_phase_e;

    localparam int MAGIC_BITS = 16;
    localparam int REQ_BITS   = 8;
    localparam int ACK_BITS   = 3;
    localparam int DATA_BITS  = 32;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    localparam logic [2:0] ST_OK     = 3'd0;
    localparam logic [2:0] ST_WAIT   = 3'd1;
    localparam logic [2:0] ST_FAULT  = 3'd2;
    localparam logic [2:0] ST_NORESP = 3'd3;
    localparam logic [2:0] ST_PARITY = 3'd4;

endpackage

// File: rtl/swd_lr_bitclk.sv
// Bit clock generator: each bit is one low half followed by one high half,
// each half lasting the half-period captured at launch (0 is treated as 1).
// Assumes launch only arrives while not running. A halt request seen at the
// end of a high half stops the clock with the line left high.
module swd_lr_bitclk #(
    parameter int HP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    input  logic [HP_W-1:0] half_period,
    input  logic            halt,
    output logic            swclk,
    output logic            sample_stb,
    output logic            bit_end
);

    logic [HP_W-1:0] hp_q;
    logic [HP_W-1:0] cnt_q;
    logic            run_q;
    logic            phase_end;

    // Last cycle of the current clock half.
    assign phase_end  = run_q && (cnt_q == (hp_q - HP_W'(1)));
    assign sample_stb = phase_end && !swclk;
    assign bit_end    = phase_end && swclk;

    // Half-period counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            swclk <= 1'b1;
            cnt_q <= '0;
            hp_q  <= HP_W'(1);
        end else if (launch) begin
            run_q <= 1'b1;
            swclk <= 1'b0;
            cnt_q <= '0;
            hp_q  <= (half_period == '0) ? HP_W'(1) : half_period;
        end else if (phase_end) begin
            cnt_q <= '0;
            if (!swclk) begin
                swclk <= 1'b1;
            end else if (halt) begin
                run_q <= 1'b0;
            end else begin
                swclk <= 1'b0;
            end
        end else if (run_q) begin
            cnt_q <= cnt_q + HP_W'(1);
        end
    end

endmodule

// File: rtl/swd_lr_seq.sv
// Phase sequencer: walks the switch pattern, idle, request, turnaround,
// acknowledge and (on OK) data, parity, turnaround and trailing idle.
// Assumes bit_end pulses once per bit and ack is complete by the end of
// the last acknowledge bit.
module swd_lr_seq
    import swd_lr_pkg::*;
#(
    parameter int ONES_BITS = 64,
    parameter int GAP_BITS  = 8,
    parameter int CNT_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bit_end,
    input  logic [2:0]       ack,
    output logic             launch,
    output logic             halt,
    output logic             finishing,
    output logic             busy,
    output logic             err_path,
    output lr_phase_e        phase,
    output logic [CNT_W-1:0] bitcnt
);

    int        phase_len;
    logic      last_bit;
    lr_phase_e next_phase;

    // Number of bits in the current phase.
    always_comb begin
        case (phase)
            PH_ONES_A, PH_ONES_B: phase_len = ONES_BITS;
            PH_MAGIC:             phase_len = MAGIC_BITS;
            PH_GAP, PH_TAIL:      phase_len = GAP_BITS;
            PH_REQ:               phase_len = REQ_BITS;
            PH_ACK:               phase_len = ACK_BITS;
            PH_DATA:              phase_len = DATA_BITS;
            default:              phase_len = 1;
        endcase
    end

    assign last_bit = (bitcnt == CNT_W'(phase_len - 1));

    // Successor phase once the current one is exhausted.
    always_comb begin
        case (phase)
            PH_ONES_A: next_phase = PH_MAGIC;
            PH_MAGIC:  next_phase = PH_ONES_B;
            PH_ONES_B: next_phase = PH_GAP;
            PH_GAP:    next_phase = PH_REQ;
            PH_REQ:    next_phase = PH_TURN_A;
            PH_TURN_A: next_phase = PH_ACK;
            PH_ACK:    next_phase = (ack == ACK_OK) ? PH_DATA : PH_TURN_B;
            PH_DATA:   next_phase = PH_PAR;
            PH_PAR:    next_phase = PH_TURN_B;
            PH_TURN_B: next_phase = PH_TAIL;
            default:   next_phase = PH_IDLE;
        endcase
    end

    assign launch    = (phase == PH_IDLE) && start;
    assign busy      = (phase != PH_IDLE);
    assign halt      = ((phase == PH_TURN_B) && err_path) ||
                       ((phase == PH_TAIL) && last_bit);
    assign finishing = bit_end && halt;

    // Phase, bit index and error-path flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            err_path <= 1'b0;
        end else if (phase == PH_IDLE) begin
            if (start) begin
                phase    <= PH_ONES_A;
                bitcnt   <= '0;
                err_path <= 1'b0;
            end
        end else if (bit_end) begin
            if (halt) begin
                phase  <= PH_IDLE;
                bitcnt <= '0;
            end else if (last_bit) begin
                phase  <= next_phase;
                bitcnt <= '0;
                if (phase == PH_ACK) begin
                    err_path <= (ack != ACK_OK);
                end
            end else begin
                bitcnt <= bitcnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/swd_lr_capture.sv
// Receive shifters: collect acknowledge, data and parity bits, first bit
// received landing in bit 0. Assumes sample_stb marks the last cycle of a
// low clock half, when the target's bit is stable.
module swd_lr_capture
    import swd_lr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic                 sample_stb,
    input  lr_phase_e            phase,
    input  logic                 swdio_in,
    output logic [ACK_BITS-1:0]  ack,
    output logic [DATA_BITS-1:0] data,
    output logic                 par
);

    // Shift the sampled line into the field for the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            ack  <= '0;
            data <= '0;
            par  <= 1'b0;
        end else if (sample_stb) begin
            case (phase)
                PH_ACK:  ack  <= {swdio_in, ack[ACK_BITS-1:1]};
                PH_DATA: data <= {swdio_in, data[DATA_BITS-1:1]};
                PH_PAR:  par  <= swdio_in;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/swd_lr_drive.sv
// Output decoder: derives the driven data value and enable from the phase
// and bit index, so no pattern storage is needed. Assumes phase and bitcnt
// change only at falling clock edges.
module swd_lr_drive
    import swd_lr_pkg::*;
#(
    parameter logic [MAGIC_BITS-1:0] SWITCH_PAT = 16'hE79E,
    parameter logic [REQ_BITS-1:0]   ID_REQ     = 8'hA5,
    parameter int                    CNT_W      = 7
) (
    input  lr_phase_e        phase,
    input  logic [CNT_W-1:0] bitcnt,
    output logic             swdio_out,
    output logic             swdio_oe
);

    logic magic_bit;
    logic req_bit;

    assign magic_bit = ((SWITCH_PAT >> bitcnt) & MAGIC_BITS'(1)) != '0;
    assign req_bit   = ((ID_REQ >> bitcnt) & REQ_BITS'(1)) != '0;

    // Per-phase line value and drive enable.
    always_comb begin
        swdio_out = 1'b1;
        swdio_oe  = 1'b0;
        case (phase)
            PH_ONES_A, PH_ONES_B: begin
                swdio_out = 1'b1;
                swdio_oe  = 1'b1;
            end
            PH_MAGIC: begin
                swdio_out = magic_bit;
                swdio_oe  = 1'b1;
            end
            PH_GAP, PH_TAIL: begin
                swdio_out = 1'b0;
                swdio_oe  = 1'b1;
            end
            PH_REQ: begin
                swdio_out = req_bit;
                swdio_oe  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/swd_line_reset.sv
// Top of the serial-wire line reset and connect sequencer. On start it
// clocks out the switch pattern, idle bits and the identification request,
// then reads the acknowledge, data and parity and reports a status.
// Assumes the target drives swdio_in stable before each rising clock edge.
module swd_line_reset
    import swd_lr_pkg::*;
#(
    parameter int                    HP_W       = 8,
    parameter int                    ONES_BITS  = 64,
    parameter int                    GAP_BITS   = 8,
    parameter logic [MAGIC_BITS-1:0] SWITCH_PAT = 16'hE79E,
    parameter logic [REQ_BITS-1:0]   ID_REQ     = 8'hA5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [HP_W-1:0] half_period,
    input  logic            swdio_in,
    output logic            swclk,
    output logic            swdio_out,
    output logic            swdio_oe,
    output logic            busy,
    output logic            done,
    output logic [31:0]     id_value,
    output logic [2:0]      status
);

    localparam int LEN_A = (ONES_BITS > DATA_BITS) ? ONES_BITS : DATA_BITS;
    localparam int LEN_M = (LEN_A > GAP_BITS) ? LEN_A : GAP_BITS;
    localparam int CNT_W = $clog2(LEN_M) + 1;

    logic                 launch;
    logic                 halt;
    logic                 finishing;
    logic                 err_path;
    logic                 sample_stb;
    logic                 bit_end;
    lr_phase_e            phase;
    logic [CNT_W-1:0]     bitcnt;
    logic [ACK_BITS-1:0]  ack;
    logic [DATA_BITS-1:0] data;
    logic                 par;

    swd_lr_bitclk #(.HP_W(HP_W)) u_bitclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .half_period(half_period),
        .halt       (halt),
        .swclk      (swclk),
        .sample_stb (sample_stb),
        .bit_end    (bit_end)
    );

    swd_lr_seq #(
        .ONES_BITS(ONES_BITS),
        .GAP_BITS (GAP_BITS),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .bit_end  (bit_end),
        .ack      (ack),
        .launch   (launch),
        .halt     (halt),
        .finishing(finishing),
        .busy     (busy),
        .err_path (err_path),
        .phase    (phase),
        .bitcnt   (bitcnt)
    );

    swd_lr_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .sample_stb(sample_stb),
        .phase     (phase),
        .swdio_in  (swdio_in),
        .ack       (ack),
        .data      (data),
        .par       (par)
    );

    swd_lr_drive #(
        .SWITCH_PAT(SWITCH_PAT),
        .ID_REQ    (ID_REQ),
        .CNT_W     (CNT_W)
    ) u_drive (
        .phase    (phase),
        .bitcnt   (bitcnt),
        .swdio_out(swdio_out),
        .swdio_oe (swdio_oe)
    );

    // Completion pulse and result registers, updated at the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            status   <= ST_NORESP;
            id_value <= '0;
        end else begin
            done <= finishing;
            if (finishing) begin
                if (err_path) begin
                    id_value <= '0;
                    case (ack)
                        ACK_WAIT:  status <= ST_WAIT;
                        ACK_FAULT: status <= ST_FAULT;
                        default:   status <= ST_NORESP;
                    endcase
                end else if ((^data) ^ par) begin
                    id_value <= '0;
                    status   <= ST_PARITY;
                end else begin
                    id_value <= data;
                    status   <= ST_OK;
                end
            end
        end
    end

endmodule

// File: rtl/swd_line_reset_chk.sv
// Property checker for the line reset sequencer, attached by bind.
// Tracks how long swclk holds each level and compares that with the
// half period captured when a run is accepted.
module swd_line_reset_chk #(
    parameter int HP_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [HP_W-1:0] half_period,
    input logic            swclk,
    input logic            swdio_out,
    input logic            swdio_oe,
    input logic            busy,
    input logic            done
);

    logic            swclk_d;
    logic [HP_W:0]   run_len;
    logic [HP_W-1:0] hp_l;

    // Level-duration counter and captured half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swclk_d <= 1'b1;
            run_len <= '0;
            hp_l    <= HP_W'(1);
        end else begin
            swclk_d <= swclk;
            run_len <= (swclk != swclk_d) ? (HP_W+1)'(1) : run_len + (HP_W+1)'(1);
            if (start && !busy) begin
                hp_l <= (half_period == '0) ? HP_W'(1) : half_period;
            end
        end
    end

    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (swclk && !swdio_oe));

    p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_busy_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_half_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (swclk != swclk_d)) |-> (run_len == {1'b0, hp_l}));

    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && swclk) |-> ($stable(swdio_out) && $stable(swdio_oe)));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

endmodule

bind swd_line_reset swd_line_reset_chk #(.HP_W(HP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .half_period(half_period),
    .swclk      (swclk),
    .swdio_out  (swdio_out),
    .swdio_oe   (swdio_oe),
    .busy       (busy),
    .done       (done)
);

// File: tb/swd_line_reset_tb.sv
// Scoreboard bench: the driver task queues the expected bit stream and
// results, the monitor pops and compares one bit per rising swclk edge and
// plays the target by driving acknowledge, data and parity.
module swd_line_reset_tb;

    localparam int HP_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [HP_W-1:0] half_period = 8'd1;
    logic            swdio_in = 1'b1;
    logic            swclk;
    logic            swdio_out;
    logic            swdio_oe;
    logic            busy;
    logic            done;
    logic [31:0]     id_value;
    logic [2:0]      status;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    logic [35:0] resp = '0;
    int rise_idx = 0;
    int since_rise = 0;
    int hp_eff = 1;
    bit mon_on = 1'b0;
    bit prev_clk = 1'b1;

    swd_line_reset #(.HP_W(HP_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .half_period(half_period),
        .swdio_in   (swdio_in),
        .swclk      (swclk),
        .swdio_out  (swdio_out),
        .swdio_oe   (swdio_oe),
        .busy       (busy),
        .done       (done),
        .id_value   (id_value),
        .status     (status)
    );

    // 50 MHz clock: 20 time units per period.
    always #10 clk = ~clk;

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(int idx);
        if (idx < 64)  return "R5";
        if (idx < 80)  return "R6";
        if (idx < 152) return "R7";
        if (idx < 161) return "R8";
        if (idx < 164) return "R9";
        return "R10";
    endfunction

    // Monitor and target model: one comparison per rising swclk edge.
    always @(negedge clk) begin
        int act;
        int e;
        int nxt;
        since_rise++;
        if (mon_on && swclk && !prev_clk) begin
            act = swdio_oe ? (swdio_out ? 1 : 0) : 2;
            if (exp_q.size() == 0) begin
                check(req_of(rise_idx), "extra bit", rise_idx, -1);
            end else begin
                e = exp_q.pop_front();
                check(req_of(rise_idx), $sformatf("bit %0d (2=released)", rise_idx), act, e);
            end
            if (rise_idx > 0) check("R3", "bit period", since_rise, 2 * hp_eff);
            since_rise = 0;
            nxt = rise_idx + 1;
            swdio_in = (nxt >= 161 && nxt <= 196) ? resp[nxt-161] : 1'b1;
            rise_idx++;
        end
        prev_clk = swclk;
    end

    task automatic run_case(string tag, int hp, logic [2:0] ack, logic [31:0] data,
                            bit bad_par, bit poke, logic [2:0] exp_st, logic [31:0] exp_id);
        logic [15:0] sw = 16'hE79E;
        logic [7:0]  rq = 8'hA5;
        int cyc = 0;
        bit got = 1'b0;
        exp_q.delete();
        for (int i = 0; i < 64; i++) exp_q.push_back(1);
        for (int i = 0; i < 16; i++) exp_q.push_back(int'(sw[i]));
        for (int i = 0; i < 64; i++) exp_q.push_back(1);
        for (int i = 0; i < 8; i++)  exp_q.push_back(0);
        for (int i = 0; i < 8; i++)  exp_q.push_back(int'(rq[i]));
        exp_q.push_back(2);
        for (int i = 0; i < 3; i++)  exp_q.push_back(2);
        if (ack == 3'b001) begin
            for (int i = 0; i < 33; i++) exp_q.push_back(2);
            exp_q.push_back(2);
            for (int i = 0; i < 8; i++) exp_q.push_back(0);
        end else begin
            exp_q.push_back(2);
        end
        resp = {(^data) ^ bad_par, data, ack};
        hp_eff = (hp == 0) ? 1 : hp;
        half_period = HP_W'(hp);
        rise_idx = 0;
        since_rise = 0;
        swdio_in = 1'b1;
        mon_on = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R2", {tag, " busy after start"}, busy, 1);
        while (!got && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            start = (poke && cyc == 100);
            if (done) got = 1'b1;
        end
        start = 1'b0;
        if (!got) begin
            checks++;
            errors++;
            $display("FAIL R11 %s watchdog: actual=0 expected=1 (done)", tag);
        end else begin
            check("R11", {tag, " busy at done"}, busy, 0);
            check("R11", {tag, " swclk at done"}, swclk, 1);
            check("R11", {tag, " oe at done"}, swdio_oe, 0);
            check("R9", {tag, " status"}, status, exp_st);
            check("R10", {tag, " id_value"}, id_value, exp_id);
            check("R12", {tag, " all bits seen"}, exp_q.size(), 0);
        end
        mon_on = 1'b0;
        swdio_in = 1'b1;
        @(negedge clk);
        check("R11", {tag, " done is one cycle"}, done, 0);
        check("R11", {tag, " status holds"}, status, exp_st);
        check("R1", {tag, " idle lines"}, {swclk, swdio_oe}, 2'b10);
    endtask

    // Global watchdog: a hung run still reaches the summary line.
    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset swclk", swclk, 1);
        check("R1", "reset oe", swdio_oe, 0);
        check("R1", "reset busy", busy, 0);
        check("R1", "reset done", done, 0);
        check("R1", "reset status", status, 3);
        check("R1", "reset id", id_value, 0);

        // R10: OK with good parity, fastest clock
        run_case("ok_hp1", 1, 3'b001, 32'h2BA01477, 1'b0, 1'b0, 3'd0, 32'h2BA01477);
        // R10: OK acknowledge with corrupted parity
        run_case("par_hp3", 3, 3'b001, 32'h0BB11477, 1'b1, 1'b0, 3'd4, 32'h0);
        // R9 and R3: WAIT with half period 0 treated as 1
        run_case("wait_hp0", 0, 3'b010, 32'h0, 1'b0, 1'b0, 3'd1, 32'h0);
        // R9: FAULT acknowledge
        run_case("fault_hp2", 2, 3'b100, 32'h0, 1'b0, 1'b0, 3'd2, 32'h0);
        // R9: undriven line reads as all ones, no response
        run_case("noresp_hp1", 1, 3'b111, 32'hFFFFFFFF, 1'b0, 1'b0, 3'd3, 32'h0);
        // R2 and R12: start pulsed mid-run is ignored, full sequence repeats
        run_case("poke_hp2", 2, 3'b001, 32'hA5A50F0F, 1'b0, 1'b1, 3'd0, 32'hA5A50F0F);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule